// File: doc/BRIEF.md
# Self-Referencing Resistive Cell Read Sequencer

This controller reads one bit from a resistive memory cell without any fixed reference level. A charge-balancing sense amplifier hands it one comparator decision per clock, meaning "add a charge quantum now". The controller keeps a signed running count of those decisions over sense windows of a run-time length. The unknown cell contents are counted upward with a weight of two windows. The controller then has a known 1 written into the same cell and counts one window downward. It does the same with a known 0. The sign of what remains is the answer.

The read destroys the stored value. After the decision, the controller therefore asks the array driver to write the decided bit back. Every write request is held until the array acknowledges it. A completed read is marked by a one-clock `done` pulse that carries the bit and an ambiguity flag. An optional mode takes a single unknown-cell window and doubles its count, which saves one window of sense time.

Top module: `resref_read_ctrl`

## Requirements
- R1: After reset, `done`, `wr_req`, `rd_bit` and `ambig` are low and the controller is idle.
- R2: `start` is accepted only while idle. A `start` that arrives during a read has no effect on that read's phase timing or result.
- R3: The unknown-cell phase begins on the clock after `start` is accepted and counts up. It lasts two windows of `win_len` clocks each, and a `win_len` of 0 is treated as 1. The count grows by one on every sense clock in which `cmp_add` is high.
- R4: With `single_win` high at start, the unknown-cell phase is one window, and its count is doubled (shifted left by one) before the next phase.
- R5: After the unknown-cell phase, `wr_req` rises with `wr_val`=1 and stays high with a stable `wr_val` until `wr_ack`. Sensing starts on the next clock and counts down for one window.
- R6: Next, `wr_req` rises with `wr_val`=0 and is held until `wr_ack`. One window of down-counting follows.
- R7: A positive net count decodes as 1 and a negative net count as 0. A net count of exactly zero decodes as 0 with `ambig`=1, and `ambig` is 0 otherwise.
- R8: One clock after the last reference window, `wr_req` rises with `wr_val` equal to the decoded bit and is held until `wr_ack`. On the next clock `done` is high for exactly one cycle, with `rd_bit` and `ambig` valid.
- R9: The count holds twice the largest window count in either direction without wrapping. A window of all-add decisions at the maximum length therefore decodes correctly.
- R10: The count is cleared when `start` is accepted, so one read's result does not depend on earlier reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a read (taken only when idle) |
| win_len | input | WIN_W | Sense window length in clocks, latched at start (0 acts as 1) |
| single_win | input | 1 | Use one doubled unknown-cell window, latched at start |
| cmp_add | input | 1 | Comparator decision: add a charge quantum this clock |
| wr_req | output | 1 | Write request to the array driver |
| wr_val | output | 1 | Bit to write while `wr_req` is high |
| wr_ack | input | 1 | Array driver accepts the write |
| done | output | 1 | One-clock completion pulse |
| rd_bit | output | 1 | Decoded bit, valid with `done` |
| ambig | output | 1 | Net count was exactly zero, valid with `done` |

## Verification
The bench builds the block with WIN_W=3, so a window is at most 7 clocks and the count needs 5 bits. With windows this short, every combination of add counts across the four windows at length 3 can be swept, and the same holds for lengths 0 and 1 in both unknown-cell modes. That covers exact zero nets, the sign decision on either side of zero, and the all-add extremes at length 7 that bound the count range. The acknowledge delay varies from run to run, and stray `start` pulses are injected during reads, to exercise the hold and ignore rules.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNK_A,
    ST_UNK_B,
    ST_WR_ONE,
    ST_REF_ONE,
    ST_WR_ZERO,
    ST_REF_ZERO,
    ST_DECIDE,
    ST_RESTORE,
    ST_DONE
  } rrs_state_e;
endpackage

// File: rtl/rrs_window_timer.sv
module rrs_window_timer #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIN_W-1:0] len_in,
  input  logic             run,
  output logic             last
);
  logic [WIN_W-1:0] len_q, len_d;
  logic [WIN_W-1:0] wcnt_q, wcnt_d;
  logic [WIN_W:0]   wcnt_inc;

  always_comb begin
    wcnt_inc = {1'b0, wcnt_q} + 1'b1;
    last     = (wcnt_inc >= {1'b0, len_q});
    len_d    = load ? len_in : len_q;
    wcnt_d   = wcnt_q;
    if (load)
      wcnt_d = '0;
    else if (run)
      wcnt_d = last ? '0 : wcnt_inc[WIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      wcnt_q <= '0;
    end else begin
      len_q  <= len_d;
      wcnt_q <= wcnt_d;
    end
  end

  // R3
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ((len_q == '0) ? (wcnt_q == '0) : (wcnt_q < len_q)));
endmodule

// File: rtl/rrs_updown_acc.sv
module rrs_updown_acc #(
  parameter int CNT_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    step_en,
  input  logic                    down,
  input  logic                    add,
  input  logic                    dbl,
  output logic signed [CNT_W-1:0] acc
);
  localparam logic signed [CNT_W-1:0] ONE = 1;

  logic signed [CNT_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = clr ? '0 : acc_q;
    if (step_en && add)
      acc_d = down ? (acc_d - ONE) : (acc_d + ONE);
    if (dbl)
      acc_d = acc_d <<< 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !dbl && !(step_en && add)) |=> $stable(acc_q));
  // R9
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !dbl && step_en && add && !down) |=> (acc_q > $past(acc_q)));
  // R9
  no_wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !dbl && step_en && add && down) |=> (acc_q < $past(acc_q)));
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !step_en && !dbl) |=> (acc_q == '0));
endmodule

// File: rtl/rrs_phase_fsm.sv
module rrs_phase_fsm
  import rrs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic single_win,
  input  logic win_last,
  input  logic wr_ack,
  input  logic acc_pos,
  input  logic acc_zero,
  output logic timer_load,
  output logic timer_run,
  output logic acc_clr,
  output logic acc_step,
  output logic acc_down,
  output logic acc_dbl,
  output logic wr_req,
  output logic wr_val,
  output logic done,
  output logic rd_bit,
  output logic ambig
);
  rrs_state_e state_q, state_d;
  logic single_q, single_d;
  logic bit_q, bit_d;
  logic amb_q, amb_d;

  always_comb begin
    state_d    = state_q;
    single_d   = single_q;
    bit_d      = bit_q;
    amb_d      = amb_q;
    timer_load = 1'b0;
    timer_run  = 1'b0;
    acc_clr    = 1'b0;
    acc_step   = 1'b0;
    acc_down   = 1'b0;
    acc_dbl    = 1'b0;
    wr_req     = 1'b0;
    wr_val     = 1'b0;
    done       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          timer_load = 1'b1;
          acc_clr    = 1'b1;
          single_d   = single_win;
          bit_d      = 1'b0;
          amb_d      = 1'b0;
          state_d    = ST_UNK_A;
        end
      end
      ST_UNK_A: begin
        timer_run = 1'b1;
        acc_step  = 1'b1;
        if (win_last) begin
          acc_dbl = single_q;
          state_d = single_q ? ST_WR_ONE : ST_UNK_B;
        end
      end
      ST_UNK_B: begin
        timer_run = 1'b1;
        acc_step  = 1'b1;
        if (win_last) state_d = ST_WR_ONE;
      end
      ST_WR_ONE: begin
        wr_req = 1'b1;
        wr_val = 1'b1;
        if (wr_ack) state_d = ST_REF_ONE;
      end
      ST_REF_ONE: begin
        timer_run = 1'b1;
        acc_step  = 1'b1;
        acc_down  = 1'b1;
        if (win_last) state_d = ST_WR_ZERO;
      end
      ST_WR_ZERO: begin
        wr_req = 1'b1;
        wr_val = 1'b0;
        if (wr_ack) state_d = ST_REF_ZERO;
      end
      ST_REF_ZERO: begin
        timer_run = 1'b1;
        acc_step  = 1'b1;
        acc_down  = 1'b1;
        if (win_last) state_d = ST_DECIDE;
      end
      ST_DECIDE: begin
        bit_d   = acc_pos;
        amb_d   = acc_zero;
        state_d = ST_RESTORE;
      end
      ST_RESTORE: begin
        wr_req = 1'b1;
        wr_val = bit_q;
        if (wr_ack) state_d = ST_DONE;
      end
      ST_DONE: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      single_q <= 1'b0;
      bit_q    <= 1'b0;
      amb_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      single_q <= single_d;
      bit_q    <= bit_d;
      amb_q    <= amb_d;
    end
  end

  assign rd_bit = bit_q;
  assign ambig  = amb_q;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_val)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  ambig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ambig) |-> !rd_bit);
  // R8
  restore_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_ack && state_q == ST_RESTORE) |=> (done && rd_bit == $past(wr_val)));
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_DONE) |=> (state_q != ST_IDLE));
endmodule

// File: rtl/resref_read_ctrl.sv
module resref_read_ctrl #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIN_W-1:0] win_len,
  input  logic             single_win,
  input  logic             cmp_add,
  output logic             wr_req,
  output logic             wr_val,
  input  logic             wr_ack,
  output logic             done,
  output logic             rd_bit,
  output logic             ambig
);
  localparam int CNT_W = WIN_W + 2;

  logic timer_load, timer_run, win_last;
  logic acc_clr, acc_step, acc_down, acc_dbl;
  logic acc_pos, acc_zero;
  logic signed [CNT_W-1:0] acc;

  rrs_window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (timer_load),
    .len_in (win_len),
    .run    (timer_run),
    .last   (win_last)
  );

  rrs_updown_acc #(.CNT_W(CNT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (acc_clr),
    .step_en (acc_step),
    .down    (acc_down),
    .add     (cmp_add),
    .dbl     (acc_dbl),
    .acc     (acc)
  );

  assign acc_zero = (acc == '0);
  assign acc_pos  = !acc[CNT_W-1] && !acc_zero;

  rrs_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .single_win (single_win),
    .win_last   (win_last),
    .wr_ack     (wr_ack),
    .acc_pos    (acc_pos),
    .acc_zero   (acc_zero),
    .timer_load (timer_load),
    .timer_run  (timer_run),
    .acc_clr    (acc_clr),
    .acc_step   (acc_step),
    .acc_down   (acc_down),
    .acc_dbl    (acc_dbl),
    .wr_req     (wr_req),
    .wr_val     (wr_val),
    .done       (done),
    .rd_bit     (rd_bit),
    .ambig      (ambig)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!done && !wr_req));
endmodule

// File: tb/resref_read_ctrl_bench.sv
module resref_read_ctrl_bench;
  localparam int WIN_W = 3;

  logic clk = 1'b0;
  logic rst_n, start, single_win, cmp_add, wr_ack;
  logic [WIN_W-1:0] win_len;
  logic wr_req, wr_val, done, rd_bit, ambig;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  resref_read_ctrl #(.WIN_W(WIN_W)) u_resref_read_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .win_len(win_len),
    .single_win(single_win), .cmp_add(cmp_add), .wr_req(wr_req),
    .wr_val(wr_val), .wr_ack(wr_ack), .done(done), .rd_bit(rd_bit),
    .ambig(ambig)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one sense window; optional stray start on its first clock (R2)
  task automatic sense_win(input int len, input int k, input bit poke, inout bit leak);
    for (int i = 0; i < len; i++) begin
      if (wr_req || done) leak = 1'b1;
      cmp_add = (i < k);
      if (poke && i == 0) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cmp_add = 1'b0;
  endtask

  task automatic take_write(input int dly, input bit expv, input string req);
    bit held = 1'b1;
    chk(wr_req === 1'b1 && wr_val === expv, req, {wr_req, wr_val}, {1'b1, expv});
    for (int j = 0; j < dly; j++) begin
      @(negedge clk);
      if (wr_req !== 1'b1 || wr_val !== expv) held = 1'b0;
    end
    chk(held, req, held, 1);
    wr_ack = 1'b1;
    @(negedge clk);
    wr_ack = 1'b0;
  endtask

  task automatic do_read(input int len, input bit single, input int a, input int b,
                         input int c, input int d, input int dly, input bit poke);
    int el = (len == 0) ? 1 : len;
    int net = (single ? 2 * a : a + b) - c - d;
    bit eb = (net > 0);
    bit ea = (net == 0);
    bit leak = 1'b0;
    win_len = WIN_W'(len);
    single_win = single;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    single_win = ~single;
    win_len = '0;
    sense_win(el, a, poke, leak);
    if (!single) sense_win(el, b, 1'b0, leak);
    chk(!leak, single ? "R4 no write during unknown window" : "R3 no write during unknown windows", leak, 0);
    take_write(dly, 1'b1, "R5 known-1 write request");
    sense_win(el, c, 1'b0, leak);
    take_write((dly + 1) % 3, 1'b0, "R6 known-0 write request");
    sense_win(el, d, 1'b0, leak);
    chk(!leak && wr_req === 1'b0, "R5 R6 phase timing", leak, 0);
    @(negedge clk);
    take_write(dly, eb, "R8 restore of decoded bit");
    chk(done === 1'b1, "R8 done pulse", done, 1);
    chk(rd_bit === eb, ea ? "R7 zero net decodes 0" : "R7 sign decision", rd_bit, eb);
    chk(ambig === ea, "R7 ambiguity flag", ambig, ea);
    @(negedge clk);
    chk(done === 1'b0 && wr_req === 1'b0, "R8 done one cycle", done, 0);
  endtask

  initial begin
    int run_id = 0;
    rst_n = 1'b0; start = 1'b0; single_win = 1'b0; cmp_add = 1'b0;
    wr_ack = 1'b0; win_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 1'b0 && wr_req === 1'b0 && rd_bit === 1'b0 && ambig === 1'b0,
        "R1 reset state", {done, wr_req, rd_bit, ambig}, 0);
    // full sweep at length 3, two unknown windows (R3 R10)
    for (int a = 0; a <= 3; a++)
      for (int b = 0; b <= 3; b++)
        for (int c = 0; c <= 3; c++)
          for (int d = 0; d <= 3; d++) begin
            do_read(3, 1'b0, a, b, c, d, run_id % 3, (run_id % 5) == 0);
            run_id++;
          end
    // single doubled window (R4)
    for (int a = 0; a <= 3; a++)
      for (int c = 0; c <= 3; c++)
        for (int d = 0; d <= 3; d++) begin
          do_read(3, 1'b1, a, 0, c, d, run_id % 3, (run_id % 4) == 1);
          run_id++;
        end
    // lengths 0 (acts as 1) and 1, both modes (R3 R4)
    for (int len = 0; len <= 1; len++)
      for (int m = 0; m < 2; m++)
        for (int v = 0; v < 16; v++) begin
          do_read(len, m[0], v & 1, (v >> 1) & 1, (v >> 2) & 1, (v >> 3) & 1, v % 3, 1'b0);
        end
    // extremes at max length (R9)
    do_read(7, 1'b0, 7, 7, 0, 0, 0, 1'b0);
    do_read(7, 1'b0, 0, 0, 7, 7, 1, 1'b0);
    do_read(7, 1'b1, 7, 0, 0, 0, 2, 1'b0);
    do_read(7, 1'b1, 0, 0, 7, 7, 0, 1'b0);
    do_read(7, 1'b0, 7, 7, 7, 7, 1, 1'b1);
    do_read(7, 1'b0, 5, 4, 6, 2, 2, 1'b0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule